// File: doc/BRIEF.md
# Block Cipher Round Sequencer

This controller steps a 64-bit lightweight block cipher datapath through one operation. After reset it waits until the master-key setup phase is over. It then accepts a single-cycle start pulse. It spends one cycle on initial whitening and then one cycle on each of the 32 rounds, driving the datapath mux select, the key-source select, the round index and the whitening-position select along the way.

When the last round is done, the result is held in a completion state until the downstream stage signals that it is ready. The result leaves on the cycle the downstream ready input is high. On that same cycle a new start pulse can be taken, so operations can run back to back.

The round function, the key schedule and the datapath registers sit outside this block. An unencoded phase value sends the controller to a trap state, and only reset brings it out.

Top module: `round_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `ready_o`, `done_o`, `last_round_o`, `key_sel_o` and `whiten_post_o` are 0, and `mux_sel_o` and `round_o` are 0. From that first cycle, the block moves to the ready phase if `key_ready_i` is high and to the key-setup phase if it is low.
- R2: While `key_ready_i` is low, the block stays in key setup with `ready_o` at 0, and `start_i` is ignored. It enters the ready phase one cycle after `key_ready_i` is sampled high. A low `key_ready_i` in the ready phase sends it back to key setup.
- R3: `ready_o` is 1 exactly when `key_ready_i` is high and the block is either in the ready phase or in the completion phase with `sink_ready_i` high. A start pulse is taken only when `ready_o` is 1.
- R4: The cycle after a start is taken is the whitening cycle. In it, `mux_sel_o`=1, `key_sel_o`=0, `whiten_post_o`=0 and `round_o`=0.
- R5: The 32 cycles after the whitening cycle are round cycles, with `round_o` counting 0 to 31 and `key_sel_o`=1. `mux_sel_o`=2 for rounds 0 to 30.
- R6: In round 31, `mux_sel_o`=3, `last_round_o`=1 and `whiten_post_o`=1. Outside round 31, `last_round_o` and `whiten_post_o` are 0.
- R7: After round 31, the block enters the completion phase. It stays there while `sink_ready_i` is low, with `done_o`, `ready_o`, `mux_sel_o` and `round_o` at 0, and `start_i` is ignored. In every phase other than whitening and rounds, `mux_sel_o` is 0.
- R8: In the completion phase with `sink_ready_i` high, `done_o` is 1 for that cycle and the block leaves. It goes to whitening if a start is taken, to key setup if `key_ready_i` is low, and to the ready phase otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_ready_i | input | 1 | Master key setup finished |
| sink_ready_i | input | 1 | Downstream stage can take the result |
| start_i | input | 1 | Single-cycle start of a cipher operation |
| ready_o | output | 1 | Start is accepted this cycle |
| done_o | output | 1 | Result leaves this cycle |
| mux_sel_o | output | 3 | Datapath select: 0 hold, 1 whiten, 2 round, 3 last round |
| last_round_o | output | 1 | Final round cycle |
| key_sel_o | output | 1 | 0 whitening key, 1 round subkey |
| round_o | output | 5 | Current round index |
| whiten_post_o | output | 1 | 0 pre-whitening, 1 post-whitening |

## Verification
The assertions assume that `start_i` is a single-cycle pulse and that the inputs are free of unknowns once reset is released. They make no assumption about how `key_ready_i` and `sink_ready_i` are ordered, so they must hold under any mix of those two.

The stimulus drives all inputs only on falling edges and always releases `start_i` after one cycle. It sends start pulses that should be ignored during key setup and during completion-phase backpressure. It lines up a start with the release of `sink_ready_i` to exercise back-to-back operation, drops `key_ready_i` at completion, and then runs a long stretch of random input activity.

// File: rtl/round_seq_pkg.sv
package round_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_KEYCFG = 3'd1,
    PH_READY  = 3'd2,
    PH_WHITEN = 3'd3,
    PH_ROUND  = 3'd4,
    PH_DONE   = 3'd5,
    PH_ERR    = 3'd6
  } phase_e;

  localparam logic [2:0] SEL_HOLD  = 3'd0;
  localparam logic [2:0] SEL_WHITE = 3'd1;
  localparam logic [2:0] SEL_ROUND = 3'd2;
  localparam logic [2:0] SEL_LAST  = 3'd3;
  localparam logic [2:0] SEL_ERR   = 3'd7;
endpackage

// File: rtl/round_seq_cnt.sv
module round_seq_cnt #(
  parameter int ROUNDS = 32,
  localparam int RIDX_W = $clog2(ROUNDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [RIDX_W-1:0] cnt_o,
  output logic              last_o
);
  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(ROUNDS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= last_o ? '0 : cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LAST_IDX);

  // R5: round index steps by one through the rounds
  assert_round_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !last_o) |=> (cnt_o == RIDX_W'($past(cnt_o) + 1'b1)));
  // R4: whitening always starts the count from zero
  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/round_seq_ctrl.sv
module round_seq_ctrl
  import round_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   key_ready_i,
  input  logic   sink_ready_i,
  input  logic   start_i,
  input  logic   last_i,
  output phase_e phase_o
);
  phase_e phase_d;

  always_comb begin
    case (phase_o)
      PH_IDLE,
      PH_KEYCFG: phase_d = key_ready_i ? PH_READY : PH_KEYCFG;
      PH_READY: begin
        if (!key_ready_i)  phase_d = PH_KEYCFG;
        else if (start_i)  phase_d = PH_WHITEN;
        else               phase_d = PH_READY;
      end
      PH_WHITEN: phase_d = PH_ROUND;
      PH_ROUND:  phase_d = last_i ? PH_DONE : PH_ROUND;
      PH_DONE: begin
        if (!sink_ready_i)     phase_d = PH_DONE;
        else if (!key_ready_i) phase_d = PH_KEYCFG;
        else if (start_i)      phase_d = PH_WHITEN;
        else                   phase_d = PH_READY;
      end
      PH_ERR:    phase_d = PH_ERR;
      default:   phase_d = PH_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= PH_IDLE;
    else         phase_o <= phase_d;
  end

  // R7: result held under backpressure
  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_DONE && !sink_ready_i) |=> (phase_o == PH_DONE));
  // R2: no operation starts while key setup is pending
  assert_key_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_KEYCFG) |=> (phase_o != PH_WHITEN));
  // R4: whitening lasts exactly one cycle
  assert_whiten_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_WHITEN) |=> (phase_o == PH_ROUND));
endmodule

// File: rtl/round_seq_dec.sv
module round_seq_dec
  import round_seq_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int RIDX_W = $clog2(ROUNDS)
) (
  input  phase_e            phase_i,
  input  logic [RIDX_W-1:0] cnt_i,
  input  logic              last_i,
  input  logic              key_ready_i,
  input  logic              sink_ready_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [2:0]        mux_sel_o,
  output logic              last_round_o,
  output logic              key_sel_o,
  output logic [RIDX_W-1:0] round_o,
  output logic              whiten_post_o
);
  logic in_round;
  logic in_done_go;

  assign in_round   = (phase_i == PH_ROUND);
  assign in_done_go = (phase_i == PH_DONE) && sink_ready_i;

  assign ready_o       = key_ready_i && ((phase_i == PH_READY) || in_done_go);
  assign done_o        = in_done_go;
  assign last_round_o  = in_round && last_i;
  assign whiten_post_o = in_round && last_i;
  assign key_sel_o     = in_round;
  assign round_o       = in_round ? cnt_i : '0;

  always_comb begin
    case (phase_i)
      PH_WHITEN: mux_sel_o = SEL_WHITE;
      PH_ROUND:  mux_sel_o = last_i ? SEL_LAST : SEL_ROUND;
      PH_ERR:    mux_sel_o = SEL_ERR;
      default:   mux_sel_o = SEL_HOLD;
    endcase
  end
endmodule

// File: rtl/round_seq.sv
module round_seq
  import round_seq_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int RIDX_W = $clog2(ROUNDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_ready_i,
  input  logic              sink_ready_i,
  input  logic              start_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [2:0]        mux_sel_o,
  output logic              last_round_o,
  output logic              key_sel_o,
  output logic [RIDX_W-1:0] round_o,
  output logic              whiten_post_o
);
  phase_e            phase;
  logic [RIDX_W-1:0] cnt;
  logic              last;

  round_seq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .key_ready_i  (key_ready_i),
    .sink_ready_i (sink_ready_i),
    .start_i      (start_i),
    .last_i       (last),
    .phase_o      (phase)
  );

  round_seq_cnt #(.ROUNDS(ROUNDS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase == PH_WHITEN),
    .inc_i  (phase == PH_ROUND),
    .cnt_o  (cnt),
    .last_o (last)
  );

  round_seq_dec #(.ROUNDS(ROUNDS)) u_dec (
    .phase_i       (phase),
    .cnt_i         (cnt),
    .last_i        (last),
    .key_ready_i   (key_ready_i),
    .sink_ready_i  (sink_ready_i),
    .ready_o       (ready_o),
    .done_o        (done_o),
    .mux_sel_o     (mux_sel_o),
    .last_round_o  (last_round_o),
    .key_sel_o     (key_sel_o),
    .round_o       (round_o),
    .whiten_post_o (whiten_post_o)
  );

  // R8: completion reported for a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4: whitening select is followed by round 0
  assert_whiten_then_r0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_sel_o == SEL_WHITE) |=> (mux_sel_o == SEL_ROUND && round_o == '0));
  // R6: final round is followed by the hold select
  assert_last_then_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_round_o |=> (!last_round_o && mux_sel_o == SEL_HOLD && !key_sel_o));
  // R3: ready implies key setup finished
  assert_ready_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> key_ready_i);
endmodule

// File: tb/round_seq_bench.sv
module round_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_rdy = 1'b1;
  logic       sink_rdy = 1'b1;
  logic       start = 1'b0;
  logic       ready, done, last_r, ksel, post;
  logic [2:0] sel;
  logic [4:0] rnd;

  int n_cmp = 0;
  int n_bad = 0;
  // model: 0 idle, 1 key setup, 2 ready, 3 whiten, 4 round, 5 done
  int m_ph = 0;
  int m_r = 0;

  round_seq u_round_seq (
    .clk_i(clk), .rst_ni(rst_n), .key_ready_i(key_rdy), .sink_ready_i(sink_rdy),
    .start_i(start), .ready_o(ready), .done_o(done), .mux_sel_o(sel),
    .last_round_o(last_r), .key_sel_o(ksel), .round_o(rnd), .whiten_post_o(post)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare();
    logic [12:0] act, exp;
    logic e_rdy, e_done, e_last;
    logic [2:0] e_sel;
    string tag;
    e_rdy  = key_rdy && (m_ph == 2 || (m_ph == 5 && sink_rdy));
    e_done = (m_ph == 5) && sink_rdy;
    e_last = (m_ph == 4) && (m_r == NR - 1);
    e_sel  = (m_ph == 3) ? 3'd1 : (m_ph == 4) ? (e_last ? 3'd3 : 3'd2) : 3'd0;
    exp = {e_rdy, e_done, e_sel, e_last, (m_ph == 4), e_last,
           (m_ph == 4) ? 5'(m_r) : 5'd0};
    act = {ready, done, sel, last_r, ksel, post, rnd};
    case (m_ph)
      0: tag = "R1";
      1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4";
      4: tag = e_last ? "R6" : "R5";
      default: tag = sink_rdy ? "R8" : "R7";
    endcase
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  task automatic model_step();
    logic acc;
    acc = key_rdy && start && (m_ph == 2 || (m_ph == 5 && sink_rdy));
    case (m_ph)
      0, 1: m_ph = key_rdy ? 2 : 1;
      2: m_ph = !key_rdy ? 1 : (acc ? 3 : 2);
      3: begin m_ph = 4; m_r = 0; end
      4: if (m_r == NR - 1) m_ph = 5; else m_r++;
      default: if (sink_rdy) m_ph = !key_rdy ? 1 : (acc ? 3 : 2);
    endcase
  endtask

  // drive inputs at negedge, compare, then advance the model at posedge
  task automatic cyc(input logic k, input logic s, input logic st);
    key_rdy = k; sink_rdy = s; start = st;
    #1;
    compare();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset values
    cyc(1, 1, 0); cyc(1, 1, 1);
    rst_n = 1'b1;
    cyc(1, 1, 0);                    // R1: first cycle after reset
    repeat (3) cyc(1, 1, 0);
    // R2: key setup, start ignored
    cyc(0, 1, 0); cyc(0, 1, 1); repeat (3) cyc(0, 1, 0);
    cyc(1, 1, 0); cyc(1, 1, 0);
    // R4 R5 R6 R8: one operation, downstream ready
    cyc(1, 1, 1);
    repeat (40) cyc(1, 1, 0);
    // R7: backpressure, start ignored during hold, then back-to-back start
    sink_rdy = 1'b0;
    cyc(1, 0, 1);
    repeat (36) cyc(1, 0, 0);
    cyc(1, 0, 1);
    repeat (5) cyc(1, 0, 0);
    cyc(1, 1, 1);                    // R8: leave DONE straight into whitening
    repeat (33) cyc(1, 0, 0);
    cyc(0, 1, 0);                    // R8: key dropped at completion
    repeat (3) cyc(0, 1, 0);
    // mixed random activity
    for (int i = 0; i < 4000; i++)
      cyc(($urandom_range(0, 15) != 0), ($urandom_range(0, 3) != 0),
          ($urandom_range(0, 5) == 0));
    // reset mid-operation
    cyc(1, 1, 0);
    rst_n = 1'b0; m_ph = 0; m_r = 0;
    cyc(1, 1, 0);
    rst_n = 1'b1;
    repeat (4) cyc(1, 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule